// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins split into two banks of eight. Software reaches it through a byte-wide register port. It writes on a one-cycle strobe, and read data follows the address combinationally. Pin n sits in bank n/8, at bit position n%8 inside that bank's shared registers.

Each pin has two registers of its own. The output-control register drives the pad controls: direction, drive type, pull enable, pull selection and output value. The input-control register shows the synchronised pin level and holds a 2-bit edge-detection code.

A matching edge sets a pending bit whether or not the pin is masked. A single interrupt line is the OR of every pending bit whose mask bit is clear. Software clears a pending bit by writing a 1 to its position. A second mask set, for the sleep state, is only stored and read back.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, all pad outputs are 0 and `irq` is 0.
- R2: The output-control byte of pin n is at 0x2B+n for n<8 and at 0x3B+(n-8) for n>=8. It stores bits 5:0, and bits 7:6 read 0. The input-control byte is at 0x33+n, or 0x43+(n-8); it stores bits 2:1, and its other stored bits read 0.
- R3: Output-control bits drive the pads of pin n: bit 5 to `pad_oe[n]`, bit 4 to `pad_od[n]`, bit 3 to `pad_pull_en[n]`, bits 2:1 to `pad_pull_sel[2n+1:2n]` and bit 0 to `pad_out[n]`.
- R4: Input-control bit 0 reads `pin_in[n]` as sampled two clock edges earlier. Writes to that bit have no effect.
- R5: Input-control bits 2:1 select detection: 0 off, 1 falling, 2 rising, 3 both. A matching edge sets bit n%8 of the pending byte, at 0x0B for bank 0 and 0x0C for bank 1. The bit is set one clock after the edge reaches the synchronised level.
- R6: The mask bytes are at 0x19 and 0x1A; a 1 suppresses that pin in `irq`. Pending bits are still captured while a pin is masked. `irq` is high whenever any unmasked pending bit is set.
- R7: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged.
- R8: An edge that matches in the same cycle as a clearing write keeps the pending bit set.
- R9: The sleep mask bytes at 0x1B and 0x1C read back what was written and have no effect on `irq`.
- R10: Reads from unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output enable per pin |
| pad_od | output | 16 | Open-drain select per pin |
| pad_pull_en | output | 16 | Pull resistor enable per pin |
| pad_pull_sel | output | 32 | Pull selection, two bits per pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `reg_addr`, `reg_wr` and `reg_wdata` are stable around each rising edge. They also assume that reset is held for at least one edge, so that the synchroniser latency check can count edges from reset release. The bench meets both assumptions by changing every input, including `pin_in`, only on falling edges. Each write strobe lasts exactly one cycle. For the edge-versus-clear case, the pin change and the clearing write are placed so that both fall on the same rising edge.

// File: rtl/gpioc_pkg.sv
// Shared constants, address helpers and the detection code type for the
// banked GPIO controller. Assumes banks of eight pins whose address blocks
// are spaced 16 bytes apart (control) or one byte apart (bank registers).
package gpioc_pkg;
    localparam int BANK_PINS   = 8;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 8;
    localparam int CTLO_W      = 6;
    localparam int BANK_STRIDE = 16;

    localparam logic [ADDR_W-1:0] CTLO_BASE  = 8'h2B;
    localparam logic [ADDR_W-1:0] CTLI_BASE  = 8'h33;
    localparam logic [ADDR_W-1:0] PEND_BASE  = 8'h0B;
    localparam logic [ADDR_W-1:0] MASK_BASE  = 8'h19;
    localparam logic [ADDR_W-1:0] SLEEP_BASE = 8'h1B;

    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2,
        DET_BOTH = 2'd3
    } det_mode_e;

    function automatic logic [ADDR_W-1:0] ctlo_addr(input int pin);
        return CTLO_BASE + ADDR_W'(BANK_STRIDE * (pin / BANK_PINS)) + ADDR_W'(pin % BANK_PINS);
    endfunction

    function automatic logic [ADDR_W-1:0] ctli_addr(input int pin);
        return CTLI_BASE + ADDR_W'(BANK_STRIDE * (pin / BANK_PINS)) + ADDR_W'(pin % BANK_PINS);
    endfunction

    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base, input int bank);
        return base + ADDR_W'(bank);
    endfunction
endpackage

// File: rtl/gpioc_sync.sv
// Two-flop synchroniser for asynchronous pin inputs, followed by a history
// flop that yields one-cycle rise and fall pulses of the synchronised level.
// Assumes pin_in may change at any time relative to clk.
module gpioc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, hist_q;
    logic [1:0]   up_cnt;

    // Synchroniser chain and one-cycle history of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~hist_q;
    assign fall  = ~sync_q & hist_q;

    // Edges counted since reset release, saturating, used by the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)            up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    assert_level_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (level == $past(pin_in, 2)));
endmodule

// File: rtl/gpioc_pending.sv
// Per-pin edge qualification and pending capture, plus the masked interrupt
// combine. Assumes rise/fall are single-cycle pulses from the synchroniser and
// clr is a one-cycle write-1-to-clear vector.
module gpioc_pending
    import gpioc_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      rise,
    input  logic [NUM_PINS-1:0]      fall,
    input  det_mode_e [NUM_PINS-1:0] mode,
    input  logic [NUM_PINS-1:0]      clr,
    input  logic [NUM_PINS-1:0]      mask,
    output logic [NUM_PINS-1:0]      pend,
    output logic                     irq
);
    logic [NUM_PINS-1:0] hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Edge qualification: falling uses code bit 0, rising uses code bit 1.
        always_comb begin
            hit[i] = (mode[i][1] & rise[i]) | (mode[i][0] & fall[i]);
        end

        // Pending flop: a new edge takes priority over a clearing write.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] & ~clr[i]) | hit[i];
        end

        assert_edge_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> pend[i]);
        assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && clr[i]) |=> pend[i]);
        assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !hit[i]) |=> !pend[i]);
        assert_zero_write_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);
        assert_off_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == DET_OFF && !pend[i]) |=> !pend[i]);
    end

    // Interrupt combine over unmasked pending bits.
    always_comb begin
        irq = |(pend & ~mask);
    end

    assert_full_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
endmodule

// File: rtl/gpioc_regfile.sv
// Register file: per-pin output and input control bytes, per-bank mask and
// sleep mask bytes, the pending clear strobe and the read multiplexer.
// Assumes a single-cycle write strobe and an address stable across the edge.
module gpioc_regfile
    import gpioc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NUM_PINS = NUM_BANKS * BANK_PINS
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wr_en,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W-1:0]                    rdata,
    input  logic [NUM_PINS-1:0]                  level,
    input  logic [NUM_PINS-1:0]                  pend,
    output logic [NUM_PINS-1:0][CTLO_W-1:0]      ctlo,
    output det_mode_e [NUM_PINS-1:0]             mode,
    output logic [NUM_PINS-1:0]                  mask,
    output logic [NUM_PINS-1:0]                  clr
);
    logic [NUM_PINS-1:0][CTLO_W-1:0] ctlo_q;
    det_mode_e [NUM_PINS-1:0]        mode_q;
    logic [NUM_PINS-1:0]             mask_q;
    logic [NUM_PINS-1:0]             sleep_q;
    logic                            mapped;

    // Register writes; unmatched addresses touch nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctlo_q  <= '0;
            mode_q  <= {NUM_PINS{DET_OFF}};
            mask_q  <= '0;
            sleep_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (addr == ctlo_addr(i)) ctlo_q[i] <= wdata[CTLO_W-1:0];
                if (addr == ctli_addr(i)) mode_q[i] <= det_mode_e'(wdata[2:1]);
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr == bank_addr(MASK_BASE, b))
                    mask_q[b*BANK_PINS +: BANK_PINS] <= wdata;
                if (addr == bank_addr(SLEEP_BASE, b))
                    sleep_q[b*BANK_PINS +: BANK_PINS] <= wdata;
            end
        end
    end

    // Write-1-to-clear strobe for the pending bytes.
    always_comb begin
        clr = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr_en && addr == bank_addr(PEND_BASE, b))
                clr[b*BANK_PINS +: BANK_PINS] = wdata;
        end
    end

    // Read multiplexer and address-hit flag.
    always_comb begin
        rdata  = '0;
        mapped = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == ctlo_addr(i)) begin
                rdata  = {{(DATA_W-CTLO_W){1'b0}}, ctlo_q[i]};
                mapped = 1'b1;
            end
            if (addr == ctli_addr(i)) begin
                rdata  = {5'b0, mode_q[i], level[i]};
                mapped = 1'b1;
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == bank_addr(PEND_BASE, b)) begin
                rdata  = pend[b*BANK_PINS +: BANK_PINS];
                mapped = 1'b1;
            end
            if (addr == bank_addr(MASK_BASE, b)) begin
                rdata  = mask_q[b*BANK_PINS +: BANK_PINS];
                mapped = 1'b1;
            end
            if (addr == bank_addr(SLEEP_BASE, b)) begin
                rdata  = sleep_q[b*BANK_PINS +: BANK_PINS];
                mapped = 1'b1;
            end
        end
    end

    assign ctlo = ctlo_q;
    assign mode = mode_q;
    assign mask = mask_q;

    assert_unmapped_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(ctlo_q) && $stable(mode_q) && $stable(mask_q) && $stable(sleep_q)));
    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the banked GPIO controller: synchroniser, register file and pending
// logic, with the output-control bits fanned out to the pad control pins.
// Assumes pin_in is asynchronous and the register port is driven synchronously.
module gpio_edge_ctrl
    import gpioc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NUM_PINS = NUM_BANKS * BANK_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [2*NUM_PINS-1:0] pad_pull_sel,
    output logic                  irq
);
    logic [NUM_PINS-1:0]             level, rise, fall, pend, mask, clr;
    logic [NUM_PINS-1:0][CTLO_W-1:0] ctlo;
    det_mode_e [NUM_PINS-1:0]        mode;

    gpioc_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpioc_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .level  (level),
        .pend   (pend),
        .ctlo   (ctlo),
        .mode   (mode),
        .mask   (mask),
        .clr    (clr)
    );

    gpioc_pending #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .fall   (fall),
        .mode   (mode),
        .clr    (clr),
        .mask   (mask),
        .pend   (pend),
        .irq    (irq)
    );

    // Pad control fan-out from each pin's output-control byte.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        assign pad_out[i]          = ctlo[i][0];
        assign pad_pull_sel[2*i+:2] = ctlo[i][2:1];
        assign pad_pull_en[i]      = ctlo[i][3];
        assign pad_od[i]           = ctlo[i][4];
        assign pad_oe[i]           = ctlo[i][5];
    end

    assert_pads_move_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull_sel)));
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
// Self-checking bench: a write/readback vector table walked by one loop,
// then directed tests for reset, pad fan-out, latency, edges and clearing.
module gpio_edge_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wen = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] pins = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_pull_en;
    logic [31:0] pad_pull_sel;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [7:0]  rv;

    always #10 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wen),
        .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pins),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel), .irq(irq)
    );

    // {address, write data, expected readback}
    localparam logic [23:0] VECS [0:14] = '{
        24'h2B_FF_3F,  // R2 pin0 output control, bits 7:6 dropped
        24'h42_15_15,  // R2 pin15 output control
        24'h32_01_01,  // R2 pin7 output control
        24'h33_FF_06,  // R4 pin0 input control, level bit not stored
        24'h3A_04_04,  // R2 pin7 input control, rising code
        24'h43_03_02,  // R5 pin8 input control, falling code
        24'h19_FF_FF,  // R6 bank0 mask
        24'h1A_3C_3C,  // R6 bank1 mask
        24'h1B_A5_A5,  // R9 bank0 sleep mask
        24'h1C_5A_5A,  // R9 bank1 sleep mask
        24'h0B_FF_00,  // R7 clear with nothing pending
        24'h2A_77_00,  // R10 unmapped
        24'h4B_77_00,  // R10 unmapped
        24'h50_FF_00,  // R10 unmapped
        24'h1D_FF_00   // R10 unmapped
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
        tick(3);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run ends as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;

        // Vector table walk: write, then read back.
        for (int k = 0; k < 15; k++) begin
            wr(VECS[k][23:16], VECS[k][15:8]);
            rd(VECS[k][23:16], rv);
            check($sformatf("vector %0d addr %h", k, VECS[k][23:16]), 32'(rv), 32'(VECS[k][7:0]));
        end

        // R1: reset state.
        do_reset();
        tick(1);
        rd(8'h2B, rv); check("R1 ctlo pin0", 32'(rv), 0);
        rd(8'h42, rv); check("R1 ctlo pin15", 32'(rv), 0);
        rd(8'h43, rv); check("R1 ctli pin8", 32'(rv), 0);
        rd(8'h19, rv); check("R1 mask bank0", 32'(rv), 0);
        rd(8'h1B, rv); check("R1 sleep bank0", 32'(rv), 0);
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 pad_pull_sel", pad_pull_sel, 0);
        check("R1 irq", 32'(irq), 0);

        // R4: level latency and ignored bit-0 write.
        @(negedge clk);
        pins[12] = 1'b1;
        addr = 8'h47;
        @(negedge clk); #1;
        check("R4 level after one edge", 32'(rdata), 0);
        @(negedge clk); #1;
        check("R4 level after two edges", 32'(rdata), 1);
        wr(8'h47, 8'h00);
        rd(8'h47, rv); check("R4 bit0 write ignored", 32'(rv), 1);

        // R3: pad fan-out.
        wr(8'h3D, 8'h3B);
        check("R3 pin10 pads", {26'd0, pad_oe[10], pad_od[10], pad_pull_en[10],
              pad_pull_sel[21:20], pad_out[10]}, 32'b111011);
        wr(8'h2E, 8'h24);
        check("R3 pin3 pads", {26'd0, pad_oe[3], pad_od[3], pad_pull_en[3],
              pad_pull_sel[7:6], pad_out[3]}, 32'b100100);
        check("R3 pad_oe vector", 32'(pad_oe), 32'h0408);

        // R5: falling detection on pin9.
        wr(8'h44, 8'h02);
        set_pin(9, 1'b1);
        rd(8'h0C, rv); check("R5 rise ignored in falling mode", 32'(rv), 0);
        check("R5 no irq yet", 32'(irq), 0);
        set_pin(9, 1'b0);
        rd(8'h0C, rv); check("R5 falling edge pending", 32'(rv), 32'h02);
        check("R6 irq on unmasked pending", 32'(irq), 1);

        // R7: zero write holds, one write clears.
        wr(8'h0C, 8'h00);
        rd(8'h0C, rv); check("R7 zero write holds", 32'(rv), 32'h02);
        wr(8'h0C, 8'h02);
        rd(8'h0C, rv); check("R7 one write clears", 32'(rv), 0);
        check("R7 irq drops", 32'(irq), 0);

        // R5: rising detection on pin2, detection off on pin0.
        wr(8'h35, 8'h04);
        set_pin(2, 1'b1);
        rd(8'h0B, rv); check("R5 rising edge pending", 32'(rv), 32'h04);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        rd(8'h0B, rv); check("R5 code 0 captures nothing", 32'(rv), 32'h04);

        // R6: mask gates irq; R9: sleep mask has no effect.
        wr(8'h19, 8'h04);
        check("R6 masked irq low", 32'(irq), 0);
        rd(8'h0B, rv); check("R6 pending kept under mask", 32'(rv), 32'h04);
        wr(8'h19, 8'h00);
        wr(8'h1B, 8'hFF);
        check("R9 sleep mask ignored by irq", 32'(irq), 1);
        rd(8'h1B, rv); check("R9 sleep mask readback", 32'(rv), 32'hFF);
        wr(8'h0B, 8'h04);
        check("R7 irq clear bank0", 32'(irq), 0);

        // R6: capture while masked, then unmask.
        wr(8'h38, 8'h06);
        wr(8'h19, 8'h20);
        set_pin(5, 1'b1);
        rd(8'h0B, rv); check("R6 captured while masked", 32'(rv), 32'h20);
        check("R6 irq held low by mask", 32'(irq), 0);
        wr(8'h19, 8'h00);
        check("R6 irq after unmask", 32'(irq), 1);

        // R8: falling edge on pin5 lands on the same edge as its clear.
        @(negedge clk);
        pins[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        addr = 8'h0B; wdata = 8'h20; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        rd(8'h0B, rv); check("R8 edge beats clear", 32'(rv), 32'h20);
        wr(8'h0B, 8'h20);
        rd(8'h0B, rv); check("R7 clear without edge", 32'(rv), 0);

        // R10: write to an unmapped neighbour leaves registers intact.
        wr(8'h4B, 8'hFF);
        rd(8'h4A, rv); check("R10 neighbour ctli unchanged", 32'(rv), 0);
        rd(8'h4B, rv); check("R10 unmapped reads zero", 32'(rv), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule